// File: doc/BRIEF.md
# Memory Buffer Register with Shift Editing and Parity

This block is the 16-bit buffer register that sits between the memory arrays and the internal write bus. It holds a word in register format: the sign in bit 16, a zero in bit 15 and the fourteen magnitude bits B14..B1 in bits 14..1. The register takes a word from memory or from the bus. When the bus value is written through one of four editing strobes, the register instead captures that value rotated or shifted. Each editing transform keeps track of where the sign bit goes.

Two word formats meet here. A memory word carries odd parity in bit 16, the sign in bit 15 and data in bits 14..1. A bus word carries the sign twice, in bits 16 and 15. Whenever a memory write is strobed, the block produces the memory word with its parity bit. When a load comes from erasable storage, it checks the incoming parity and latches a sticky alarm if the word holds an even number of ones. The alarm stays set until the clear input is pulsed. All control inputs are single-cycle strobes. The RAM and ROM arrays are outside this block.

Top module: `membuf_edit`

## Requirements
- R1: After reset the register holds zero and the parity alarm is low. With the read and memory-write strobes high, the bus shows 0x0000 and the memory word shows 0x8000.
- R2: A bus write stores {bus_in[16], 0, bus_in[14:1]} in the register. Bit positions are numbered 16..1, with bit 16 as the MSB.
- R3: A memory load stores {mem_in[15], 0, mem_in[14:1]}, which moves the memory sign from bit 15 to bit 16.
- R4: While rd_bus is high, bus_out is {G16, G16, G14..G1}. While rd_bus is low, bus_out is zero.
- R5: While mem_wr is high, mem_wdata is {P, G16, G14..G1}, where P makes the count of ones over all 16 bits odd. While mem_wr is low, mem_wdata is zero.
- R6: Rotate-right edit of a bus value with sign S and data B14..B1 stores, from bit 16 down to bit 1: B1, 0, S, B14..B2.
- R7: Shift-right edit stores S, 0, S, B14..B2.
- R8: Rotate-left edit stores B14, 0, B13..B1, S.
- R9: The seven-place right-shift edit stores B14..B8 in bits 7..1 and zeros in bits 16..8.
- R10: A memory load with mem_erasable high and an even number of ones in mem_in sets the alarm. A load with mem_erasable low never sets it, whatever its parity.
- R11: Once set, the alarm stays high until alarm_clr is pulsed. If a set and a clear arrive in the same cycle, the set wins.
- R12: When several load strobes are high together, exactly one is served, in this order: memory load, bus write, rotate right, shift right, rotate left, seven-place shift.
- R13: In a cycle with no load or edit strobe, the register keeps its value, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alarm_clr | input | 1 | Clears the sticky parity alarm |
| bus_in | input | 16 | Write-bus word (sign in bits 16 and 15) |
| mem_in | input | 16 | Word read from memory (parity, sign, data) |
| mem_erasable | input | 1 | High when mem_in comes from erasable storage |
| ld_mem | input | 1 | Load register from mem_in |
| wr_bus | input | 1 | Load register from bus_in |
| rd_bus | input | 1 | Drive the register onto bus_out |
| mem_wr | input | 1 | Present the register as a memory word with parity |
| ed_rotr | input | 1 | Rotate-right edit of bus_in |
| ed_shr | input | 1 | Shift-right edit of bus_in |
| ed_rotl | input | 1 | Rotate-left edit of bus_in |
| ed_shr7 | input | 1 | Seven-place right-shift edit of bus_in |
| bus_out | output | 16 | Register in bus format, zero when not read |
| mem_wdata | output | 16 | Register in memory format with odd parity, zero when not written |
| par_alarm | output | 1 | Sticky parity alarm |

## Verification
The assertions check on every cycle the things that hold regardless of the data value. These are the duplicated sign on a bus read, the zero outputs when idle, the odd weight of every memory word, memory-load precedence, retention of the register when no strobe is high, and the setting and stickiness of the alarm. The exact bit placement of each editing transform is shown only by the bench. It sweeps hundreds of words through every edit, load and read path and compares them with values assembled independently. The bench scenarios also cover the order among simultaneous strobes, fixed-memory loads that leave the alarm alone, and a clear that collides with a set.

// File: rtl/mb_pkg.sv
package mb_pkg;

    // Register source chosen for the next cycle
    typedef enum logic [2:0] {
        SRC_HOLD = 3'd0,
        SRC_MEM  = 3'd1,
        SRC_BUS  = 3'd2,
        SRC_ROTR = 3'd3,
        SRC_SHR  = 3'd4,
        SRC_ROTL = 3'd5,
        SRC_SHRN = 3'd6
    } mb_src_e;

endpackage

// File: rtl/mb_select.sv
module mb_select
    import mb_pkg::*;
(
    input  logic    ld_mem,
    input  logic    wr_bus,
    input  logic    ed_rotr,
    input  logic    ed_shr,
    input  logic    ed_rotl,
    input  logic    ed_shr7,
    output mb_src_e src
);

    // Fixed precedence: memory, bus, then the edit strobes
    always_comb begin
        if (ld_mem)       src = SRC_MEM;
        else if (wr_bus)  src = SRC_BUS;
        else if (ed_rotr) src = SRC_ROTR;
        else if (ed_shr)  src = SRC_SHR;
        else if (ed_rotl) src = SRC_ROTL;
        else if (ed_shr7) src = SRC_SHRN;
        else              src = SRC_HOLD;
    end

endmodule

// File: rtl/mb_parity.sv
module mb_parity #(
    parameter int N = 15
) (
    input  logic [N-1:0] data,
    output logic         odd_fill
);

    // High when data has an even count of ones: the bit that makes it odd
    assign odd_fill = ~^data;

endmodule

// File: rtl/mb_editor.sv
module mb_editor
    import mb_pkg::*;
#(
    parameter int DATA_W   = 14,
    parameter int ED_SHIFT = 7
) (
    input  mb_src_e             src,
    input  logic [DATA_W+1:0]   g_cur,
    input  logic [DATA_W+1:0]   bus_in,
    input  logic [DATA_W+1:0]   mem_in,
    output logic [DATA_W+1:0]   g_next
);

    localparam int W    = DATA_W + 2;
    localparam int KEEP = DATA_W - ED_SHIFT;

    logic              sg;
    logic [DATA_W-1:0] mag;
    logic [W-1:0]      shn;

    assign sg  = bus_in[W-1];
    assign mag = bus_in[DATA_W-1:0];

    // Long right shift: surviving upper magnitude bits land at the bottom
    for (genvar k = 0; k < W; k++) begin : g_shn
        if (k < KEEP) begin : g_keep
            assign shn[k] = mag[k+ED_SHIFT];
        end else begin : g_zero
            assign shn[k] = 1'b0;
        end
    end

    always_comb begin
        unique case (src)
            SRC_MEM:  g_next = {mem_in[DATA_W], 1'b0, mem_in[DATA_W-1:0]};
            SRC_BUS:  g_next = {sg, 1'b0, mag};
            SRC_ROTR: g_next = {mag[0], 1'b0, sg, mag[DATA_W-1:1]};
            SRC_SHR:  g_next = {sg, 1'b0, sg, mag[DATA_W-1:1]};
            SRC_ROTL: g_next = {mag[DATA_W-1], 1'b0, mag[DATA_W-2:0], sg};
            SRC_SHRN: g_next = shn;
            default:  g_next = g_cur;
        endcase
    end

endmodule

// File: rtl/membuf_edit.sv
module membuf_edit
    import mb_pkg::*;
#(
    parameter int DATA_W   = 14,
    parameter int ED_SHIFT = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alarm_clr,
    input  logic [DATA_W+1:0]   bus_in,
    input  logic [DATA_W+1:0]   mem_in,
    input  logic                mem_erasable,
    input  logic                ld_mem,
    input  logic                wr_bus,
    input  logic                rd_bus,
    input  logic                mem_wr,
    input  logic                ed_rotr,
    input  logic                ed_shr,
    input  logic                ed_rotl,
    input  logic                ed_shr7,
    output logic [DATA_W+1:0]   bus_out,
    output logic [DATA_W+1:0]   mem_wdata,
    output logic                par_alarm
);

    localparam int W = DATA_W + 2;

    typedef struct packed {
        logic [W-1:0] g;
        logic         alarm;
    } mb_state_t;

    mb_state_t    st_d, st_q;
    mb_src_e      src;
    logic [W-1:0] g_next;
    logic [W-1:0] g_q;
    logic         par_bit;
    logic         mem_even;

    assign g_q = st_q.g;

    mb_select u_sel (
        .ld_mem  (ld_mem),
        .wr_bus  (wr_bus),
        .ed_rotr (ed_rotr),
        .ed_shr  (ed_shr),
        .ed_rotl (ed_rotl),
        .ed_shr7 (ed_shr7),
        .src     (src)
    );

    mb_editor #(.DATA_W(DATA_W), .ED_SHIFT(ED_SHIFT)) u_edit (
        .src    (src),
        .g_cur  (g_q),
        .bus_in (bus_in),
        .mem_in (mem_in),
        .g_next (g_next)
    );

    // Parity for the outgoing memory word: sign plus magnitude
    mb_parity #(.N(DATA_W + 1)) u_pgen (
        .data     ({g_q[W-1], g_q[DATA_W-1:0]}),
        .odd_fill (par_bit)
    );

    // Check of an incoming memory word: high means even weight
    mb_parity #(.N(W)) u_pchk (
        .data     (mem_in),
        .odd_fill (mem_even)
    );

    always_comb begin
        st_d.g     = g_next;
        st_d.alarm = st_q.alarm;
        if (alarm_clr)
            st_d.alarm = 1'b0;
        if (ld_mem && mem_erasable && mem_even)
            st_d.alarm = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign bus_out   = rd_bus ? {g_q[W-1], g_q[W-1], g_q[DATA_W-1:0]} : '0;
    assign mem_wdata = mem_wr ? {par_bit, g_q[W-1], g_q[DATA_W-1:0]} : '0;
    assign par_alarm = st_q.alarm;

endmodule

// File: rtl/mb_checker.sv
module mb_checker #(
    parameter int DATA_W = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                alarm_clr,
    input logic [DATA_W+1:0]   mem_in,
    input logic                mem_erasable,
    input logic                ld_mem,
    input logic                wr_bus,
    input logic                rd_bus,
    input logic                mem_wr,
    input logic                ed_rotr,
    input logic                ed_shr,
    input logic                ed_rotl,
    input logic                ed_shr7,
    input logic [DATA_W+1:0]   bus_out,
    input logic [DATA_W+1:0]   mem_wdata,
    input logic                par_alarm,
    input logic [DATA_W+1:0]   g_q
);

    localparam int W = DATA_W + 2;

    logic any_load;
    assign any_load = ld_mem | wr_bus | ed_rotr | ed_shr | ed_rotl | ed_shr7;

    AST_RD_SIGN_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bus |-> bus_out[W-1] == bus_out[W-2]);                          // R4
    AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_bus |-> bus_out == '0);                                        // R4
    AST_ODD_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($countones(mem_wdata) % 2) == 1);                      // R5
    AST_MEMWD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr |-> mem_wdata == '0);                                      // R5
    AST_MEM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ld_mem |=> g_q == {$past(mem_in[DATA_W]), 1'b0, $past(mem_in[DATA_W-1:0])}); // R12
    AST_ALARM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_mem && mem_erasable && (^mem_in) == 1'b0) |=> par_alarm);      // R10
    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (par_alarm && !alarm_clr) |=> par_alarm);                          // R11
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !any_load |=> $stable(g_q));                                       // R13

endmodule

bind membuf_edit mb_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alarm_clr    (alarm_clr),
    .mem_in       (mem_in),
    .mem_erasable (mem_erasable),
    .ld_mem       (ld_mem),
    .wr_bus       (wr_bus),
    .rd_bus       (rd_bus),
    .mem_wr       (mem_wr),
    .ed_rotr      (ed_rotr),
    .ed_shr       (ed_shr),
    .ed_rotl      (ed_rotl),
    .ed_shr7      (ed_shr7),
    .bus_out      (bus_out),
    .mem_wdata    (mem_wdata),
    .par_alarm    (par_alarm),
    .g_q          (g_q)
);

// File: tb/sim_membuf_edit.sv
module sim_membuf_edit;

    localparam time CYC = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alarm_clr = 1'b0;
    logic [15:0] bus_in = '0;
    logic [15:0] mem_in = '0;
    logic        mem_erasable = 1'b0;
    logic        ld_mem = 1'b0, wr_bus = 1'b0, rd_bus = 1'b0, mem_wr = 1'b0;
    logic        ed_rotr = 1'b0, ed_shr = 1'b0, ed_rotl = 1'b0, ed_shr7 = 1'b0;
    logic [15:0] bus_out, mem_wdata;
    logic        par_alarm;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CYC/2) clk = ~clk;

    membuf_edit u0 (
        .clk(clk), .rst_n(rst_n), .alarm_clr(alarm_clr),
        .bus_in(bus_in), .mem_in(mem_in), .mem_erasable(mem_erasable),
        .ld_mem(ld_mem), .wr_bus(wr_bus), .rd_bus(rd_bus), .mem_wr(mem_wr),
        .ed_rotr(ed_rotr), .ed_shr(ed_shr), .ed_rotl(ed_rotl), .ed_shr7(ed_shr7),
        .bus_out(bus_out), .mem_wdata(mem_wdata), .par_alarm(par_alarm)
    );

    // Expected register contents per requirement
    function automatic logic [15:0] x_bus(input logic [15:0] w);  return {w[15], 1'b0, w[13:0]}; endfunction           // R2
    function automatic logic [15:0] x_mem(input logic [15:0] w);  return {w[14], 1'b0, w[13:0]}; endfunction           // R3
    function automatic logic [15:0] x_rotr(input logic [15:0] w); return {w[0], 1'b0, w[15], w[13:1]}; endfunction     // R6
    function automatic logic [15:0] x_shr(input logic [15:0] w);  return {w[15], 1'b0, w[15], w[13:1]}; endfunction    // R7
    function automatic logic [15:0] x_rotl(input logic [15:0] w); return {w[13], 1'b0, w[12:0], w[15]}; endfunction   // R8
    function automatic logic [15:0] x_sh7(input logic [15:0] w);  return {9'd0, w[13:7]}; endfunction                  // R9

    function automatic logic [15:0] view_bus(input logic [15:0] g);
        return {g[15], g[15], g[13:0]};
    endfunction

    function automatic logic [15:0] view_mem(input logic [15:0] g);
        int ones = 0;
        for (int b = 0; b < 16; b++) if (b != 14 && g[b]) ones++;
        return {(ones % 2 == 0), g[15], g[13:0]};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_strobes();
        ld_mem = 0; wr_bus = 0; ed_rotr = 0; ed_shr = 0; ed_rotl = 0; ed_shr7 = 0;
        alarm_clr = 0;
    endtask

    task automatic check_g(input string req, input logic [15:0] g);
        chk(req, bus_out, view_bus(g));
        chk(req, mem_wdata, view_mem(g));
    endtask

    // op: 0 bus, 1 rotr, 2 shr, 3 rotl, 4 sh7
    task automatic do_op(input int op, input logic [15:0] w);
        @(negedge clk);
        bus_in = w;
        case (op)
            0: wr_bus = 1;
            1: ed_rotr = 1;
            2: ed_shr = 1;
            3: ed_rotl = 1;
            default: ed_shr7 = 1;
        endcase
        @(negedge clk);
        clear_strobes();
        #1;
        case (op)
            0: check_g("R2", x_bus(w));
            1: check_g("R6", x_rotr(w));
            2: check_g("R7", x_shr(w));
            3: check_g("R8", x_rotl(w));
            default: check_g("R9", x_sh7(w));
        endcase
    endtask

    task automatic do_load(input logic [15:0] w, input logic era);
        logic bad;
        bad = era && ((^w) == 1'b0);
        @(negedge clk);
        mem_in = w; mem_erasable = era; ld_mem = 1;
        @(negedge clk);
        clear_strobes();
        #1;
        check_g("R3", x_mem(w));
        chk("R10", {15'd0, par_alarm}, {15'd0, bad});
        if (bad) begin
            @(negedge clk); #1;
            chk("R11", {15'd0, par_alarm}, 16'd1);
            @(negedge clk); alarm_clr = 1;
            @(negedge clk); alarm_clr = 0; #1;
            chk("R11", {15'd0, par_alarm}, 16'd0);
        end
    endtask

    initial begin
        #(CYC * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] w, g_ref;
        repeat (3) @(negedge clk);
        rst_n = 1;
        rd_bus = 1; mem_wr = 1;
        #1;
        chk("R1", bus_out, 16'h0000);
        chk("R1", mem_wdata, 16'h8000);
        chk("R1", {15'd0, par_alarm}, 16'd0);

        // R4/R5 idle outputs
        @(negedge clk); do_op(0, 16'hC001);
        @(negedge clk); rd_bus = 0; mem_wr = 0; #1;
        chk("R4", bus_out, 16'h0000);
        chk("R5", mem_wdata, 16'h0000);
        rd_bus = 1; mem_wr = 1;

        // Sweep of edit and bus paths
        for (int i = 0; i < 600; i++) begin
            w = 16'(i * 40503 + (i >> 3) * 7);
            for (int op = 0; op < 5; op++) do_op(op, w);
        end
        // Walking ones through every path
        for (int b = 0; b < 16; b++) begin
            for (int op = 0; op < 5; op++) do_op(op, 16'(1 << b));
        end

        // Memory loads, erasable and fixed, varied parity (R3, R10, R11)
        for (int i = 0; i < 300; i++) do_load(16'(i * 2654 + 13), i[0]);
        do_load(16'h0000, 1'b0);
        do_load(16'h0000, 1'b1);

        // R11: set and clear in the same cycle, set wins
        @(negedge clk);
        mem_in = 16'h0003; mem_erasable = 1; ld_mem = 1; alarm_clr = 1;
        @(negedge clk); clear_strobes(); #1;
        chk("R11", {15'd0, par_alarm}, 16'd1);
        @(negedge clk); alarm_clr = 1;
        @(negedge clk); alarm_clr = 0; #1;
        chk("R11", {15'd0, par_alarm}, 16'd0);

        // R12: precedence among simultaneous strobes
        @(negedge clk);
        mem_in = 16'h2A5B; bus_in = 16'h9F0E;
        ld_mem = 1; wr_bus = 1; ed_rotr = 1; ed_shr7 = 1; mem_erasable = 0;
        @(negedge clk); clear_strobes(); #1;
        check_g("R12", x_mem(16'h2A5B));
        @(negedge clk); bus_in = 16'h9F0E; wr_bus = 1; ed_rotr = 1; ed_shr = 1;
        @(negedge clk); clear_strobes(); #1;
        check_g("R12", x_bus(16'h9F0E));
        @(negedge clk); bus_in = 16'h9F0F; ed_rotr = 1; ed_shr = 1; ed_rotl = 1;
        @(negedge clk); clear_strobes(); #1;
        check_g("R12", x_rotr(16'h9F0F));
        @(negedge clk); bus_in = 16'h9F0F; ed_shr = 1; ed_rotl = 1; ed_shr7 = 1;
        @(negedge clk); clear_strobes(); #1;
        check_g("R12", x_shr(16'h9F0F));
        @(negedge clk); bus_in = 16'h9F0F; ed_rotl = 1; ed_shr7 = 1;
        @(negedge clk); clear_strobes(); #1;
        check_g("R12", x_rotl(16'h9F0F));

        // R13: hold while data inputs move
        g_ref = x_rotl(16'h9F0F);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            bus_in = 16'(i * 777); mem_in = 16'(i * 4099); mem_erasable = 1;
            #1;
            check_g("R13", g_ref);
        end
        chk("R13", {15'd0, par_alarm}, 16'd0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule